// File: doc/BRIEF.md
# Mixed-Page-Size Translation Cache with Flush Controls

This block is a small, fully associative translation cache that sits in front of a page table walker. Each entry holds one virtual-to-physical mapping together with its page size: 4 KB, 64 KB or 1 MB. A lookup is compared against every entry at once. A single matching entry returns the physical address in the same cycle. When nothing matches, the block raises a walk request. The walker later writes the result back through the fill port. The replacement target is an empty entry if one exists, and otherwise the least recently used entry.

Software controls the cache through three strobes. The first drops every entry. The second takes an address word and drops every entry whose page covers that address. The third announces that a new page table base has been loaded, which also drops every entry. If a lookup finds more than one matching entry, that is a fault. The fault is reported on one of two flags, chosen by the channel that issued the lookup: read or write.

Top module: `xlate_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses and both fault flags are low.
- R2: A lookup that matches exactly one entry raises `lk_hit` in the same cycle. `lk_paddr` is then the entry's physical page bits above the page size, combined with the lookup's virtual bits below it.
- R3: Page size code 0 selects 4 KB (compares virtual bits [31:12]), code 1 selects 64 KB (bits [31:16]) and code 2 selects 1 MB (bits [31:20]). All three sizes may coexist in the array.
- R4: A valid lookup that matches no entry drives `walk_req` high and `lk_hit` low in the same cycle.
- R5: A fill writes the lowest-numbered empty entry. When the array is full, a fill replaces the least recently used entry. Both a fill and a single-entry hit make that entry the most recently used.
- R6: A `flush_all` strobe invalidates every entry from the next cycle on.
- R7: `flush_ent_wr` with `flush_ent_data` bit 0 set invalidates every entry whose page covers the address in bits [31:12]. With bit 0 clear, the write has no effect.
- R8: A `ptbase_wr` strobe, which signals that a new page table base has been loaded, invalidates every entry exactly as a full flush does.
- R9: Any flush strobe in the same cycle as `fill_valid` wins, and the fill is discarded.
- R10: A lookup matching two or more entries gives `lk_hit` low and `walk_req` low. In the following cycle it raises `mh_rd_fault` for a read lookup (`lk_write`=0) or `mh_wr_fault` for a write lookup (`lk_write`=1), and only that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup channel: 1 write, 0 read |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Exactly one entry matches |
| lk_paddr | output | 32 | Translated address, valid with lk_hit |
| walk_req | output | 1 | Miss, walk required |
| fill_valid | input | 1 | Write a new mapping |
| fill_vaddr | input | 32 | Virtual address of the new mapping |
| fill_paddr | input | 32 | Physical address of the new mapping |
| fill_size | input | 2 | Page size code of the new mapping |
| flush_all | input | 1 | Invalidate all entries |
| flush_ent_wr | input | 1 | Address-flush strobe |
| flush_ent_data | input | 32 | Address-flush word: page address and valid bit 0 |
| ptbase_wr | input | 1 | New page table base loaded |
| mh_rd_fault | output | 1 | Multi-hit on a read lookup, one cycle late |
| mh_wr_fault | output | 1 | Multi-hit on a write lookup, one cycle late |

## Verification
The bench puts pages of all three sizes into the array together. It then probes just inside and just outside each page boundary, because a design with a wrong compare mask would hit a neighbouring page or miss its own offset. It fills the array completely, refreshes the oldest entry by hitting it, and then fills again; a broken age update would evict the refreshed entry instead of the next oldest. It forces two entries to hold the same page to cause a multi-hit, and checks that the fault lands on the channel that issued the lookup and that neither a hit nor a walk is reported. It also checks that an address flush with its valid bit clear leaves the array untouched, and that a flush issued together with a fill discards the fill.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam int ADDR_W = 32;
  localparam logic [1:0] SZ_4K  = 2'd0;
  localparam logic [1:0] SZ_64K = 2'd1;
  localparam logic [1:0] SZ_1M  = 2'd2;

  // Bits set where the page number lives for a given size code.
  function automatic logic [ADDR_W-1:0] page_mask(input logic [1:0] sz);
    logic [ADDR_W-1:0] m;
    case (sz)
      SZ_64K:  m = {{(ADDR_W-16){1'b1}}, 16'h0};
      SZ_1M:   m = {{(ADDR_W-20){1'b1}}, 20'h0};
      default: m = {{(ADDR_W-12){1'b1}}, 12'h0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xtlb_match.sv
module xtlb_match
  import xtlb_pkg::*;
(
  input  logic              ent_valid,
  input  logic [ADDR_W-1:0] ent_va,
  input  logic [1:0]        ent_size,
  input  logic [ADDR_W-1:0] probe_va,
  output logic              match
);
  logic [ADDR_W-1:0] mask;
  assign mask  = page_mask(ent_size);
  assign match = ent_valid && (((ent_va ^ probe_va) & mask) == '0);
endmodule

// File: rtl/xtlb_lru.sv
module xtlb_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [IDX_W-1:0] age_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)         age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IDX_W'(ENTRIES-1)) oldest_idx = IDX_W'(i);
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xtlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_paddr,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_vaddr,
  input  logic [ADDR_W-1:0] fill_paddr,
  input  logic [1:0]        fill_size,
  input  logic              flush_all,
  input  logic              flush_ent_wr,
  input  logic [ADDR_W-1:0] flush_ent_data,
  input  logic              ptbase_wr,
  output logic              mh_rd_fault,
  output logic              mh_wr_fault
);
  logic [ADDR_W-1:0] va_q [ENTRIES];
  logic [ADDR_W-1:0] pa_q [ENTRIES];
  logic [1:0]        sz_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [ADDR_W-1:0]  fl_addr;
  assign fl_addr = {flush_ent_data[ADDR_W-1:12], 12'h0};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xtlb_match u_lk (.ent_valid(vld_q[g]), .ent_va(va_q[g]), .ent_size(sz_q[g]),
                     .probe_va(lk_vaddr), .match(lk_match[g]));
    xtlb_match u_fl (.ent_valid(vld_q[g]), .ent_va(va_q[g]), .ent_size(sz_q[g]),
                     .probe_va(fl_addr), .match(fl_match[g]));
  end

  // Hit encode and match count
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W:0]     hit_cnt;
  always_comb begin
    hit_idx = '0;
    hit_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_idx = IDX_W'(i);
        hit_cnt = hit_cnt + 1'b1;
      end
    end
  end

  logic single_hit, multi_hit;
  assign single_hit = lk_valid && (hit_cnt == 1);
  assign multi_hit  = lk_valid && (hit_cnt > 1);
  assign lk_hit     = single_hit;
  assign walk_req   = lk_valid && (hit_cnt == 0);

  logic [ADDR_W-1:0] hit_mask;
  assign hit_mask = page_mask(sz_q[hit_idx]);
  assign lk_paddr = (pa_q[hit_idx] & hit_mask) | (lk_vaddr & ~hit_mask);

  // Victim choice: lowest empty entry, else least recently used
  logic [IDX_W-1:0] lru_idx, victim;
  logic             any_free;
  always_comb begin
    any_free = 1'b0;
    victim   = lru_idx;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        any_free = 1'b1;
        victim   = IDX_W'(i);
      end
    end
  end

  logic flush_any, fe_go, fill_go;
  assign fe_go     = flush_ent_wr && flush_ent_data[0];
  assign flush_any = flush_all || ptbase_wr || fe_go;
  assign fill_go   = fill_valid && !flush_any;

  xtlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(fill_go || (single_hit && !flush_any)),
    .touch_idx(fill_go ? victim : hit_idx),
    .oldest_idx(lru_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (flush_all || ptbase_wr) begin
      vld_q <= '0;
    end else if (fe_go) begin
      vld_q <= vld_q & ~fl_match;
    end else if (fill_go) begin
      vld_q[victim] <= 1'b1;
    end
  end

  // Entry payload, no reset: qualified by vld_q
  always_ff @(posedge clk) begin
    if (fill_go) begin
      va_q[victim] <= fill_vaddr & page_mask(fill_size);
      pa_q[victim] <= fill_paddr & page_mask(fill_size);
      sz_q[victim] <= fill_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mh_rd_fault <= 1'b0;
      mh_wr_fault <= 1'b0;
    end else begin
      mh_rd_fault <= multi_hit && !lk_write;
      mh_wr_fault <= multi_hit && lk_write;
    end
  end

  logic unused_free;
  assign unused_free = any_free;
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_write,
  input logic lk_hit,
  input logic walk_req,
  input logic flush_all,
  input logic ptbase_wr,
  input logic mh_rd_fault,
  input logic mh_wr_fault
);
  // R4: a hit never asks for a walk, and a walk needs a lookup
  p_hit_no_walk_r4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !walk_req);
  p_walk_needs_lookup_r4: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> lk_valid);
  // R6: nothing survives a full flush
  p_flush_all_r6: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !lk_hit);
  // R8: table base load empties the array
  p_ptbase_r8: assert property (@(posedge clk) disable iff (rst)
    ptbase_wr |=> !lk_hit);
  // R10: fault flags exclusive and tied to the lookup channel
  p_mh_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mh_rd_fault && mh_wr_fault));
  p_mh_rd_src_r10: assert property (@(posedge clk) disable iff (rst)
    mh_rd_fault |-> $past(lk_valid && !lk_write));
  p_mh_wr_src_r10: assert property (@(posedge clk) disable iff (rst)
    mh_wr_fault |-> $past(lk_valid && lk_write));
endmodule

bind xlate_tlb xlate_tlb_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_hit(lk_hit), .walk_req(walk_req), .flush_all(flush_all),
  .ptbase_wr(ptbase_wr), .mh_rd_fault(mh_rd_fault), .mh_wr_fault(mh_wr_fault)
);

// File: tb/xlate_tlb_tb_top.sv
module xlate_tlb_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic lk_hit, walk_req, mh_rd_fault, mh_wr_fault;
  logic [31:0] lk_paddr;
  logic fill_valid = 0;
  logic [31:0] fill_vaddr = '0, fill_paddr = '0;
  logic [1:0] fill_size = '0;
  logic flush_all = 0, flush_ent_wr = 0, ptbase_wr = 0;
  logic [31:0] flush_ent_data = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlate_tlb dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // Lookup: sample hit/pa/walk in the same cycle
  task automatic look(input logic [31:0] va, input bit wr, input bit exp_hit,
                      input logic [31:0] exp_pa, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_write = wr; lk_vaddr = va;
    #1;
    chk(lk_hit == exp_hit, tag, {31'b0, lk_hit}, {31'b0, exp_hit});
    chk(walk_req == !exp_hit, tag, {31'b0, walk_req}, {31'b0, !exp_hit});
    if (exp_hit) chk(lk_paddr == exp_pa, tag, lk_paddr, exp_pa);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic strobe_all();
    @(negedge clk); flush_all = 1; @(negedge clk); flush_all = 0;
  endtask

  task automatic strobe_ent(input logic [31:0] w);
    @(negedge clk); flush_ent_wr = 1; flush_ent_data = w;
    @(negedge clk); flush_ent_wr = 0;
  endtask

  task automatic t_reset();
    look(32'h0000_1000, 0, 0, 0, "R1 reset miss");
    chk(!mh_rd_fault && !mh_wr_fault, "R1 faults low", {30'b0, mh_rd_fault, mh_wr_fault}, 0);
  endtask

  task automatic t_sizes();
    fill(32'h4000_0000, 32'h8000_0000, 2'd2);
    fill(32'h1234_0000, 32'h0056_0000, 2'd1);
    fill(32'h0000_3000, 32'h7777_7000, 2'd0);
    look(32'h400A_BCDE, 0, 1, 32'h800A_BCDE, "R2 R3 1M hit");
    look(32'h4010_0000, 0, 0, 0, "R3 1M edge miss");
    look(32'h1234_F00F, 1, 1, 32'h0056_F00F, "R2 R3 64K hit");
    look(32'h1235_0000, 0, 0, 0, "R3 64K edge miss");
    look(32'h0000_3FFF, 0, 1, 32'h7777_7FFF, "R2 R3 4K hit");
    look(32'h0000_4000, 0, 0, 0, "R4 4K edge miss");
  endtask

  task automatic t_entry_flush();
    strobe_ent(32'h1234_5000);  // valid bit clear: ignored
    look(32'h1234_0010, 0, 1, 32'h0056_0010, "R7 ignored flush");
    strobe_ent(32'h400A_B001);
    look(32'h4000_0000, 0, 0, 0, "R7 1M flushed");
    look(32'h0000_3000, 0, 1, 32'h7777_7000, "R7 other kept");
    strobe_ent(32'h1234_5001);
    look(32'h1234_0000, 0, 0, 0, "R7 64K flushed");
  endtask

  task automatic t_lru();
    strobe_all();
    look(32'h0000_3000, 0, 0, 0, "R6 all flushed");
    for (int i = 0; i < 8; i++) fill(32'h0010_0000 + i*32'h1000, 32'hA000_0000 + i*32'h1000, 2'd0);
    look(32'h0010_0000, 0, 1, 32'hA000_0000, "R5 refresh e0");
    fill(32'h0020_0000, 32'hB000_0000, 2'd0);
    look(32'h0010_1000, 0, 0, 0, "R5 LRU evicted");
    look(32'h0010_0000, 0, 1, 32'hA000_0000, "R5 refreshed kept");
    look(32'h0020_0004, 0, 1, 32'hB000_0004, "R5 new entry");
    look(32'h0010_2000, 0, 1, 32'hA000_2000, "R5 next kept");
  endtask

  task automatic t_priority();
    @(negedge clk);
    fill_valid = 1; fill_vaddr = 32'h0055_5000; fill_paddr = 32'h1; fill_size = 0; flush_all = 1;
    @(negedge clk);
    fill_valid = 0; flush_all = 0;
    look(32'h0055_5000, 0, 0, 0, "R9 fill dropped");
    fill(32'h0066_6000, 32'hC000_0000, 2'd0);
    @(negedge clk); ptbase_wr = 1; @(negedge clk); ptbase_wr = 0;
    look(32'h0066_6000, 0, 0, 0, "R8 ptbase flush");
  endtask

  task automatic t_multihit(input bit wr);
    strobe_all();
    fill(32'h0000_9000, 32'hD000_0000, 2'd0);
    fill(32'h0000_9000, 32'hE000_0000, 2'd0);
    @(negedge clk);
    lk_valid = 1; lk_write = wr; lk_vaddr = 32'h0000_9123;
    #1;
    chk(!lk_hit && !walk_req, "R10 no hit no walk", {30'b0, lk_hit, walk_req}, 0);
    @(negedge clk);
    lk_valid = 0;
    #1;
    chk(mh_rd_fault == !wr && mh_wr_fault == wr, "R10 channel flag",
        {30'b0, mh_rd_fault, mh_wr_fault}, {30'b0, !wr, wr});
    @(negedge clk); #1;
    chk(!mh_rd_fault && !mh_wr_fault, "R10 pulse ends", {30'b0, mh_rd_fault, mh_wr_fault}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_sizes();
    t_entry_flush();
    t_lru();
    t_priority();
    t_multihit(0);
    t_multihit(1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule